// File: doc/BRIEF.md
# Windowed Watchdog with Clock Monitor

This block supervises a processor core in two ways. A window counter advances on every instruction-cycle tick and has to be serviced while its count lies between a fixed lower limit and an upper limit chosen by a two-bit select code. A service write issued too soon is a fault. Letting the count reach the upper limit without a service is also a fault. A valid service write restarts the count and loads a new select code and a monitor-enable bit.

Beside the window counter, a clock monitor watches a slow reference tick that comes from a clock source that does not stop. If a whole reference period passes without a single cycle tick, the monitor reports a fault. Halt mode suppresses the cycle ticks, so the monitor catches a core that enters halt by accident. The window counter holds its value while halted.

All faults are sticky until reset. They are reported on a dedicated error pin and on two cause flags. The select code and the monitor enable both leave reset set, so the block comes up armed with the widest window.

Top module: `wdt_window_cm`

## Requirements
- R1: After reset all three error outputs are low, the select code is 3 (widest window) and the clock monitor is enabled.
- R2: A service write while the count is below 2^LO_LOG2 sets the watchdog flag on that clock edge.
- R3: A service write while the count is at least 2^LO_LOG2 does not set the watchdog flag. It clears the count to zero and loads the select code and the monitor enable from the write fields.
- R4: With select code s the upper limit is U = 2^(UP_BASE_LOG2+s). After U-1 counted ticks with no service the flag is still low, and the U-th tick sets it.
- R5: Every error output stays set until reset, whatever the later stimulus. The error pin is high exactly when either cause flag is high.
- R6: When the monitor is enabled, a reference tick that ends a period with no cycle tick in it sets the clock-monitor flag.
- R7: While halt is high, cycle ticks are ignored. The window count holds its value, and the clock monitor treats the period as having no ticks.
- R8: When the monitor enable is 0, missing cycle ticks never set the clock-monitor flag.
- R9: While cycle ticks keep arriving, reference ticks do not set the clock-monitor flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cyc_tick_i | input | 1 | Instruction-cycle tick, one clock wide |
| halt_i | input | 1 | Halt mode; suppresses cycle ticks |
| svc_wr_i | input | 1 | Service write strobe |
| svc_win_sel_i | input | 2 | Window select code written by a service |
| svc_cm_en_i | input | 1 | Clock-monitor enable written by a service |
| ref_tick_i | input | 1 | Slow reference tick for the clock monitor |
| err_pin_o | output | 1 | Sticky error pin (any fault) |
| wd_flag_o | output | 1 | Sticky window-violation flag |
| cm_flag_o | output | 1 | Sticky clock-monitor flag |

## Verification
If the window count is wrong, a service write lands on the wrong side of the lower limit or the expiry comes one tick early or late. The bench sweeps the service point across the lower boundary and the expiry across every select code, so such an error shows on the watchdog flag in the very cycle the bench samples. A count that does not hold during halt shows up as a late fault after a long halt. A stale seen-tick state in the monitor changes the clock-monitor flag right after the second reference tick of a halt.

// File: rtl/wdt_window_cm_pkg.sv
`timescale 1ns/1ps
package wdt_window_cm_pkg;
   localparam int unsigned SEL_W = 2;

   typedef struct packed {
      logic [SEL_W-1:0] win_sel;
      logic             cm_en;
   } wdcfg_t;

   localparam wdcfg_t CFG_RESET = '{win_sel: '1, cm_en: 1'b1};

   function automatic int unsigned cnt_width(input int unsigned base_log2);
      return base_log2 + (1 << SEL_W) - 1;
   endfunction
endpackage

// File: rtl/wdt_window_cm_cfg.sv
`timescale 1ns/1ps
module wdt_window_cm_cfg
   import wdt_window_cm_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             cm_en_i,
   output wdcfg_t           cfg_o
);
   wdcfg_t cfg_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cfg_q <= CFG_RESET;
      end else if (load_i) begin
         cfg_q.win_sel <= sel_i;
         cfg_q.cm_en   <= cm_en_i;
      end
   end

   assign cfg_o = cfg_q;
endmodule

// File: rtl/wdt_window_cm_window.sv
`timescale 1ns/1ps
module wdt_window_cm_window
   import wdt_window_cm_pkg::*;
#(
   parameter int unsigned LO_LOG2      = 8,
   parameter int unsigned UP_BASE_LOG2 = 13,
   localparam int unsigned CNT_W       = cnt_width(UP_BASE_LOG2),
   localparam int unsigned NSEL        = 1 << SEL_W
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             svc_wr_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             svc_early_o,
   output logic             svc_ok_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] LOWER = CNT_W'(1) << LO_LOG2;

   logic [CNT_W-1:0] cnt_q;
   logic [NSEL-1:0]  last_vec;
   logic             at_last;
   logic             below_lo;

   for (genvar s = 0; s < NSEL; s++) begin : g_lim
      localparam int unsigned SHIFT = CNT_W - (UP_BASE_LOG2 + s);
      localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}} >> SHIFT;
      assign last_vec[s] = (cnt_q == LAST);
   end

   assign at_last  = last_vec[sel_i];
   assign below_lo = (cnt_q < LOWER);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (svc_wr_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
      end
   end

   assign svc_early_o = svc_wr_i & below_lo;
   assign svc_ok_o    = svc_wr_i & ~below_lo;
   assign expire_o    = tick_i & at_last & ~svc_wr_i;
   assign cnt_o       = cnt_q;
endmodule

// File: rtl/wdt_window_cm_clkmon.sv
`timescale 1ns/1ps
module wdt_window_cm_clkmon (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic ref_tick_i,
   input  logic enable_i,
   output logic miss_o
);
   logic seen_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         seen_q <= 1'b0;
      end else if (ref_tick_i) begin
         seen_q <= 1'b0;
      end else if (tick_i) begin
         seen_q <= 1'b1;
      end
   end

   assign miss_o = ref_tick_i & enable_i & ~seen_q & ~tick_i;
endmodule

// File: rtl/wdt_window_cm_fault.sv
`timescale 1ns/1ps
module wdt_window_cm_fault (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wd_set_i,
   input  logic cm_set_i,
   output logic pin_o,
   output logic wd_o,
   output logic cm_o
);
   logic pin_q, wd_q, cm_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pin_q <= 1'b0;
         wd_q  <= 1'b0;
         cm_q  <= 1'b0;
      end else begin
         pin_q <= pin_q | wd_set_i | cm_set_i;
         wd_q  <= wd_q  | wd_set_i;
         cm_q  <= cm_q  | cm_set_i;
      end
   end

   assign pin_o = pin_q;
   assign wd_o  = wd_q;
   assign cm_o  = cm_q;
endmodule

// File: rtl/wdt_window_cm.sv
`timescale 1ns/1ps
module wdt_window_cm
   import wdt_window_cm_pkg::*;
#(
   parameter int unsigned LO_LOG2      = 8,
   parameter int unsigned UP_BASE_LOG2 = 13
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cyc_tick_i,
   input  logic             halt_i,
   input  logic             svc_wr_i,
   input  logic [SEL_W-1:0] svc_win_sel_i,
   input  logic             svc_cm_en_i,
   input  logic             ref_tick_i,
   output logic             err_pin_o,
   output logic             wd_flag_o,
   output logic             cm_flag_o
);
   localparam int unsigned CNT_W = cnt_width(UP_BASE_LOG2);

   initial begin
      assert (LO_LOG2 >= 1 && LO_LOG2 < UP_BASE_LOG2)
         else $error("lower limit must sit below the smallest upper limit");
      assert (CNT_W <= 32)
         else $error("window count wider than 32 bits");
   end

   wdcfg_t           cfg;
   logic             eff_tick;
   logic [CNT_W-1:0] cnt;
   logic             svc_early, svc_ok, expire, miss;

   assign eff_tick = cyc_tick_i & ~halt_i;

   wdt_window_cm_cfg u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (svc_ok),
      .sel_i   (svc_win_sel_i),
      .cm_en_i (svc_cm_en_i),
      .cfg_o   (cfg)
   );

   wdt_window_cm_window #(
      .LO_LOG2      (LO_LOG2),
      .UP_BASE_LOG2 (UP_BASE_LOG2)
   ) u_win (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (eff_tick),
      .svc_wr_i    (svc_wr_i),
      .sel_i       (cfg.win_sel),
      .cnt_o       (cnt),
      .svc_early_o (svc_early),
      .svc_ok_o    (svc_ok),
      .expire_o    (expire)
   );

   wdt_window_cm_clkmon u_cm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (eff_tick),
      .ref_tick_i (ref_tick_i),
      .enable_i   (cfg.cm_en),
      .miss_o     (miss)
   );

   wdt_window_cm_fault u_flt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wd_set_i (svc_early | expire),
      .cm_set_i (miss),
      .pin_o    (err_pin_o),
      .wd_o     (wd_flag_o),
      .cm_o     (cm_flag_o)
   );
endmodule

// File: rtl/wdt_window_cm_chk.sv
`timescale 1ns/1ps
module wdt_window_cm_chk
   import wdt_window_cm_pkg::*;
#(
   parameter int unsigned LO_LOG2      = 8,
   parameter int unsigned UP_BASE_LOG2 = 13,
   localparam int unsigned CNT_W       = cnt_width(UP_BASE_LOG2)
)(
   input logic             clk_i,
   input logic             rst_ni,
   input logic             eff_tick,
   input logic             svc_wr_i,
   input logic             ref_tick_i,
   input logic [CNT_W-1:0] cnt,
   input logic [SEL_W-1:0] sel,
   input logic             cm_en,
   input logic             seen,
   input logic             err_pin_o,
   input logic             wd_flag_o,
   input logic             cm_flag_o
);
   logic [CNT_W:0] up_last;
   assign up_last = ((CNT_W+1)'(1) << (UP_BASE_LOG2 + sel)) - (CNT_W+1)'(1);

   p_early_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (svc_wr_i && cnt < (CNT_W'(1) << LO_LOG2)) |=> wd_flag_o);

   p_svc_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      svc_wr_i |=> (cnt == '0));

   p_late_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eff_tick && !svc_wr_i && {1'b0, cnt} == up_last) |=> wd_flag_o);

   p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      {1'b0, cnt} <= up_last);

   p_pin_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_pin_o |=> err_pin_o);

   p_wd_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wd_flag_o |=> wd_flag_o);

   p_pin_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_pin_o == (wd_flag_o || cm_flag_o));

   p_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ref_tick_i && cm_en && !seen && !eff_tick) |=> cm_flag_o);

   p_halt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!eff_tick && !svc_wr_i) |=> $stable(cnt));

   p_cm_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cm_en && !cm_flag_o) |=> !cm_flag_o);
endmodule

bind wdt_window_cm wdt_window_cm_chk #(
   .LO_LOG2      (LO_LOG2),
   .UP_BASE_LOG2 (UP_BASE_LOG2)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .eff_tick   (eff_tick),
   .svc_wr_i   (svc_wr_i),
   .ref_tick_i (ref_tick_i),
   .cnt        (cnt),
   .sel        (cfg.win_sel),
   .cm_en      (cfg.cm_en),
   .seen       (u_cm.seen_q),
   .err_pin_o  (err_pin_o),
   .wd_flag_o  (wd_flag_o),
   .cm_flag_o  (cm_flag_o)
);

// File: tb/wdt_window_cm_tb_top.sv
`timescale 1ns/1ps
module wdt_window_cm_tb_top;
   localparam int unsigned LO   = 2;
   localparam int unsigned BASE = 4;
   localparam int unsigned LOWER = 1 << LO;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_tick = 1'b1;
   logic       halt = 1'b0;
   logic       svc_wr = 1'b0;
   logic [1:0] svc_sel = 2'd3;
   logic       svc_cmen = 1'b1;
   logic       ref_tick = 1'b0;
   logic       err_pin, wd_flag, cm_flag;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   wdt_window_cm #(.LO_LOG2(LO), .UP_BASE_LOG2(BASE)) dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .cyc_tick_i    (cyc_tick),
      .halt_i        (halt),
      .svc_wr_i      (svc_wr),
      .svc_win_sel_i (svc_sel),
      .svc_cm_en_i   (svc_cmen),
      .ref_tick_i    (ref_tick),
      .err_pin_o     (err_pin),
      .wd_flag_o     (wd_flag),
      .cm_flag_o     (cm_flag)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; halt = 1'b0; svc_wr = 1'b0; ref_tick = 1'b0; cyc_tick = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic service(input logic [1:0] sel, input logic cmen);
      svc_wr = 1'b1; svc_sel = sel; svc_cmen = cmen;
      @(negedge clk);
      svc_wr = 1'b0;
   endtask

   task automatic pulse_ref();
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
   endtask

   initial begin
      do_reset();
      check("R1 pin after reset", err_pin, 0);
      check("R1 wd flag after reset", wd_flag, 0);
      check("R1 cm flag after reset", cm_flag, 0);
      // R1/R4: reset select code 3 gives U = 2^(BASE+3)
      run((1 << (BASE + 3)) - 1);
      check("R1 R4 default window not yet expired", wd_flag, 0);
      run(1);
      check("R1 R4 default window expires", wd_flag, 1);
      check("R5 pin follows wd flag", err_pin, 1);

      // R2/R3: sweep the service point across the lower limit
      for (int n = 0; n < 2 * LOWER; n++) begin
         do_reset();
         run(n);
         service(2'd3, 1'b1);
         check($sformatf("R2 R3 service after %0d ticks", n), wd_flag, (n < LOWER) ? 1 : 0);
      end

      // R4: expiry for every select code; R5: stickiness afterwards
      for (int s = 0; s < 4; s++) begin
         int up;
         up = 1 << (BASE + s);
         do_reset();
         run(LOWER);
         service(2'(s), 1'b1);
         run(up - 1);
         check($sformatf("R4 sel %0d at U-1", s), wd_flag, 0);
         run(1);
         check($sformatf("R4 sel %0d at U", s), wd_flag, 1);
         run(LOWER + 1);
         service(2'(s), 1'b1);
         run(3);
         check($sformatf("R5 sel %0d wd stays set", s), wd_flag, 1);
         check($sformatf("R5 sel %0d pin stays set", s), err_pin, 1);
      end

      // R3: service on the last legal count, then a too-early one
      do_reset();
      run(LOWER);
      service(2'd0, 1'b1);
      run((1 << BASE) - 1);
      service(2'd0, 1'b1);
      check("R3 service at U-1 is valid", wd_flag, 0);
      run(LOWER - 1);
      service(2'd0, 1'b1);
      check("R2 early after valid service", wd_flag, 1);

      // R9 then R6/R7: ticks present, then halt removes them
      do_reset();
      run(10);
      pulse_ref();
      run(10);
      pulse_ref();
      check("R9 no cm fault with ticks", cm_flag, 0);
      run(5);
      halt = 1'b1;
      run(200);
      pulse_ref();
      check("R6 period with ticks before halt", cm_flag, 0);
      run(20);
      pulse_ref();
      check("R6 R7 halted period flagged", cm_flag, 1);
      check("R5 pin follows cm flag", err_pin, 1);
      check("R7 wd untouched during halt", wd_flag, 0);
      halt = 1'b0;
      run(10);
      pulse_ref();
      check("R5 cm flag sticky", cm_flag, 1);

      // R7: count holds while halted
      do_reset();
      run(LOWER - 1);
      halt = 1'b1;
      run(300);
      halt = 1'b0;
      run(1);
      service(2'd0, 1'b1);
      check("R7 count held during halt", wd_flag, 0);

      // R8: monitor disabled by a service write
      do_reset();
      run(LOWER + 1);
      service(2'd3, 1'b0);
      halt = 1'b1;
      pulse_ref();
      run(5);
      pulse_ref();
      run(5);
      pulse_ref();
      check("R8 cm disabled no flag", cm_flag, 0);
      check("R8 pin stays low", err_pin, 0);
      halt = 1'b0;

      // R1: reset clears sticky state
      do_reset();
      check("R1 R5 reset clears pin", err_pin, 0);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule